// File: doc/BRIEF.md
# PHY Link-Mode Management Engine

This block keeps one MAC port's link state and connection mode (speed, duplex, flow control) in step with an external PHY. A 2-bit mode input picks one of four behaviours. Two behaviours run a sequence of PHY register accesses through a request/response management master. The other two ignore the PHY and force the link down or up. The forced-up mode takes speed, duplex and flow control from three locally supplied bits.

In full hardware negotiation, the engine first programs the PHY's advertisement and control registers. It then polls the basic status register at a programmable interval. When the link is up, it also reads a resolved-status register and loads the port mode from it. In poll-only mode the engine never writes the PHY. It only watches the link bit and leaves the connection mode to software. Software typically answers a link-change interrupt by forcing the link up with the resolved settings for a moment, then returns to poll-only mode. A sticky interrupt flags every change of the tracked link state, and software clears it by writing 1. Serial management framing lies outside the block; it issues register-level requests only.

Top module: `phy_link_mgr`

## Requirements
- R1: After reset, link_up, link_irq, speed_10, half_duplex, flow_off and md_req_valid are all 0.
- R2: In mode 00, the first two requests after entering the mode are writes. The first writes adv_value to register 4 and the second writes 16'h1200 to register 0, both before any read.
- R3: In mode 00, a read of register 1 with bit 2 set is followed by a read of register stat_reg. From that data: bit 1 clear gives speed_10=1 (set means 100 Mbps), bit 0 clear gives half_duplex=1, and bit 2 clear gives flow_off=1. link_up then becomes 1.
- R4: In mode 01, the engine issues no writes and reads only register 1, and link_up follows bit 2 of the data read.
- R5: In modes 00 and 01, any change of the tracked link state sets link_irq. The flag stays set until irq_clear is pulsed, and a new change wins over a clear in the same cycle.
- R6: A pulse on irq_clear while no link change occurs returns link_irq to 0.
- R7: In mode 10, link_up is 0 and no management request is issued.
- R8: In mode 11, link_up is 1 with no management request, and {speed_10, half_duplex, flow_off} follow force_cfg[2], force_cfg[1] and force_cfg[0] (1 = 10 Mbps, half duplex, flow control off).
- R9: In mode 01, force_cfg has no effect, and speed_10, half_duplex and flow_off keep the last values loaded.
- R10: At most one request is outstanding: after a request is accepted, no new request is raised until its response has arrived.
- R11: While polling, two consecutive reads of register 1 are at least poll_interval cycles apart.
- R12: Any change of mode restarts the sequence. Entering mode 00 from another mode begins again with the write to register 4.
- R13: The forced modes do not alter the tracked link state. Returning from mode 11 to mode 01 while the PHY still reports link up raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 hardware negotiation, 01 poll only, 10 force down, 11 force up |
| force_cfg | input | 3 | Forced mode bits: [2] 10 Mbps, [1] half duplex, [0] flow control off |
| poll_interval | input | POLL_W | Idle cycles between link polls |
| phy_addr | input | PHY_AW | Address of the managed PHY |
| stat_reg | input | REG_AW | Register number of the PHY resolved-status register |
| adv_value | input | DW | Value written to the advertisement register |
| irq_clear | input | 1 | Write-1 pulse clearing link_irq |
| md_req_valid | output | 1 | Management request valid |
| md_req_ready | input | 1 | Management master accepts the request |
| md_req_write | output | 1 | 1 = register write, 0 = register read |
| md_req_phy | output | PHY_AW | PHY address of the request |
| md_req_reg | output | REG_AW | Register number of the request |
| md_req_wdata | output | DW | Write data |
| md_rsp_valid | input | 1 | One-cycle completion of the outstanding request |
| md_rsp_rdata | input | DW | Read data returned with the completion |
| link_up | output | 1 | Resolved link state |
| speed_10 | output | 1 | 1 = 10 Mbps, 0 = 100 Mbps |
| half_duplex | output | 1 | 1 = half duplex |
| flow_off | output | 1 | 1 = flow control disabled |
| link_irq | output | 1 | Sticky link-change interrupt |

## Verification
The assertions assume the management master answers every accepted request, including writes, with exactly one md_rsp_valid pulse. They also assume it never pulses md_rsp_valid when nothing is outstanding. The bench's PHY model holds md_req_ready high and answers each accepted request a fixed three cycles later. It also counts any request raised while a response is still due. Mode and force_cfg change only on falling edges. When a mode change lands while a read is in flight, the late response still arrives, and the engine must discard it.

// File: rtl/phy_link_mgr.sv
module phy_link_mgr #(
  parameter int PHY_AW      = 5,
  parameter int REG_AW      = 5,
  parameter int DW          = 16,
  parameter int POLL_W      = 16,
  parameter int ADV_REG     = 4,
  parameter int CTL_REG     = 0,
  parameter int BSR_REG     = 1,
  parameter int CTL_RESTART = 16'h1200,
  parameter int LINK_BIT    = 2,
  parameter int SPD_BIT     = 1,
  parameter int DPX_BIT     = 0,
  parameter int PAUSE_BIT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [2:0]        force_cfg,
  input  logic [POLL_W-1:0] poll_interval,
  input  logic [PHY_AW-1:0] phy_addr,
  input  logic [REG_AW-1:0] stat_reg,
  input  logic [DW-1:0]     adv_value,
  input  logic              irq_clear,
  output logic              md_req_valid,
  input  logic              md_req_ready,
  output logic              md_req_write,
  output logic [PHY_AW-1:0] md_req_phy,
  output logic [REG_AW-1:0] md_req_reg,
  output logic [DW-1:0]     md_req_wdata,
  input  logic              md_rsp_valid,
  input  logic [DW-1:0]     md_rsp_rdata,
  output logic              link_up,
  output logic              speed_10,
  output logic              half_duplex,
  output logic              flow_off,
  output logic              link_irq
);

  typedef enum logic [2:0] {S_IDLE, S_WR_ADV, S_WR_CTL, S_RD_LINK, S_RD_STAT, S_WAIT} st_t;

  localparam logic [1:0] M_HW   = 2'b00;
  localparam logic [1:0] M_POLL = 2'b01;
  localparam logic [1:0] M_DOWN = 2'b10;
  localparam logic [1:0] M_UP   = 2'b11;

  st_t              st;
  logic [1:0]       mode_q;
  logic             pend, drop;
  logic [POLL_W-1:0] cnt;
  logic             link_st;
  logic [2:0]       cfg;
  logic             irq_q;

  logic restart, issuing, accept, done, rd_link;
  logic upd, upd_val, link_chg;
  st_t  start_st;

  assign restart  = mode != mode_q;
  assign issuing  = st == S_WR_ADV || st == S_WR_CTL || st == S_RD_LINK || st == S_RD_STAT;
  assign accept   = md_req_valid && md_req_ready;
  assign done     = pend && md_rsp_valid && !drop && !restart;
  assign rd_link  = md_rsp_rdata[LINK_BIT];

  assign md_req_valid = issuing && !pend && !restart;
  assign md_req_write = st == S_WR_ADV || st == S_WR_CTL;
  assign md_req_phy   = phy_addr;
  assign md_req_wdata = (st == S_WR_ADV) ? adv_value :
                        (st == S_WR_CTL) ? DW'(CTL_RESTART) : '0;

  always_comb begin
    case (st)
      S_WR_ADV:  md_req_reg = REG_AW'(ADV_REG);
      S_WR_CTL:  md_req_reg = REG_AW'(CTL_REG);
      S_RD_LINK: md_req_reg = REG_AW'(BSR_REG);
      default:   md_req_reg = stat_reg;
    endcase
  end

  always_comb begin
    case (mode)
      M_HW:    start_st = S_WR_ADV;
      M_POLL:  start_st = S_RD_LINK;
      default: start_st = S_IDLE;
    endcase
  end

  // link state commits: poll-only on every status read, negotiation on
  // link loss or once the resolved mode has been read
  always_comb begin
    upd     = 1'b0;
    upd_val = link_st;
    if (done && st == S_RD_LINK && (mode_q == M_POLL || !rd_link)) begin
      upd     = 1'b1;
      upd_val = rd_link;
    end else if (done && st == S_RD_STAT) begin
      upd     = 1'b1;
      upd_val = 1'b1;
    end
  end
  assign link_chg = upd && (upd_val != link_st);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      mode_q  <= M_DOWN;
      pend    <= 1'b0;
      drop    <= 1'b0;
      cnt     <= '0;
      link_st <= 1'b0;
      cfg     <= 3'b000;
      irq_q   <= 1'b0;
    end else begin
      if (restart) begin
        mode_q <= mode;
        st     <= start_st;
        pend   <= pend && !md_rsp_valid;
        drop   <= (pend && !md_rsp_valid) || (drop && !md_rsp_valid);
      end else begin
        if (accept) pend <= 1'b1;
        if (pend && md_rsp_valid) begin
          pend <= 1'b0;
          drop <= 1'b0;
        end
        if (done) begin
          case (st)
            S_WR_ADV: st <= S_WR_CTL;
            S_WR_CTL: st <= S_RD_LINK;
            S_RD_LINK: begin
              if (mode_q == M_HW && rd_link) st <= S_RD_STAT;
              else begin
                st  <= S_WAIT;
                cnt <= poll_interval;
              end
            end
            S_RD_STAT: begin
              st  <= S_WAIT;
              cnt <= poll_interval;
              cfg <= {!md_rsp_rdata[SPD_BIT], !md_rsp_rdata[DPX_BIT], !md_rsp_rdata[PAUSE_BIT]};
            end
            default: st <= st;
          endcase
        end
        if (st == S_WAIT) begin
          if (cnt == '0) st <= S_RD_LINK;
          else cnt <= cnt - 1'b1;
        end
      end
      if (mode_q == M_UP) cfg <= force_cfg;
      if (upd) link_st <= upd_val;
      if (link_chg) irq_q <= 1'b1;
      else if (irq_clear) irq_q <= 1'b0;
    end
  end

  assign link_up     = (mode_q == M_UP) || (!mode_q[1] && link_st);
  assign speed_10    = cfg[2];
  assign half_duplex = cfg[1];
  assign flow_off    = cfg[0];
  assign link_irq    = irq_q;

  p_single_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    md_req_valid && md_req_ready |=> !md_req_valid)
    else $error("second request raised while one is outstanding");

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    md_req_valid && !md_req_ready && !restart |=> md_req_valid || restart)
    else $error("request withdrawn before acceptance");

  p_poll_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    md_req_valid && mode_q == M_POLL |-> !md_req_write && md_req_reg == REG_AW'(BSR_REG))
    else $error("poll-only mode issued something other than a status read");

  p_forced_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |-> !md_req_valid)
    else $error("request issued in a forced mode");

  p_forced_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_q) == M_UP |-> {speed_10, half_duplex, flow_off} == $past(force_cfg))
    else $error("forced-up mode bits not applied");

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_q) == M_POLL |-> $stable({speed_10, half_duplex, flow_off}))
    else $error("connection mode moved in poll-only mode");

  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    link_irq && !irq_clear |=> link_irq)
    else $error("interrupt dropped without a clear");

endmodule

// File: tb/phy_link_mgr_tb.sv
module phy_link_mgr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b10;
  logic [2:0]  force_cfg = 3'b000;
  logic [15:0] poll_interval = 16'd20;
  logic [4:0]  phy_addr = 5'd3;
  logic [4:0]  stat_reg = 5'd17;
  logic [15:0] adv_value = 16'h01E1;
  logic        irq_clear = 1'b0;
  logic        md_req_valid, md_req_write;
  logic        md_req_ready = 1'b1;
  logic [4:0]  md_req_phy, md_req_reg;
  logic [15:0] md_req_wdata;
  logic        md_rsp_valid = 1'b0;
  logic [15:0] md_rsp_rdata = 16'h0;
  logic        link_up, speed_10, half_duplex, flow_off, link_irq;

  always #2 clk = ~clk;

  phy_link_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .force_cfg(force_cfg),
    .poll_interval(poll_interval), .phy_addr(phy_addr), .stat_reg(stat_reg),
    .adv_value(adv_value), .irq_clear(irq_clear),
    .md_req_valid(md_req_valid), .md_req_ready(md_req_ready),
    .md_req_write(md_req_write), .md_req_phy(md_req_phy), .md_req_reg(md_req_reg),
    .md_req_wdata(md_req_wdata), .md_rsp_valid(md_rsp_valid), .md_rsp_rdata(md_rsp_rdata),
    .link_up(link_up), .speed_10(speed_10), .half_duplex(half_duplex),
    .flow_off(flow_off), .link_irq(link_irq));

  int total = 0, bad = 0, cyc = 0;
  logic        phy_link = 1'b0;
  logic [15:0] phy_stat = 16'h0;
  int n_req = 0, n_wr = 0, n_other = 0, overlap = 0;
  int last_rd = -1, min_gap = 1000000;
  logic        lw [4];
  logic [4:0]  lr [4];
  logic [15:0] ld [4];
  bit          busy = 0;
  int          lat = 0;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // PHY management model: every accepted request completes three cycles later
  initial forever begin
    @(negedge clk);
    md_rsp_valid = 1'b0;
    if (busy) begin
      if (lat == 0) begin
        md_rsp_valid = 1'b1;
        busy = 0;
      end else lat--;
    end
    if (md_req_valid && md_req_ready) begin
      if (busy || md_rsp_valid) overlap++;
      if (n_req < 4) begin
        lw[n_req] = md_req_write;
        lr[n_req] = md_req_reg;
        ld[n_req] = md_req_wdata;
      end
      n_req++;
      if (md_req_write) n_wr++;
      else if (md_req_reg != 5'd1) n_other++;
      if (!md_req_write && md_req_reg == 5'd1) begin
        if (last_rd >= 0 && cyc - last_rd < min_gap) min_gap = cyc - last_rd;
        last_rd = cyc;
      end
      if (md_req_reg == 5'd1) md_rsp_rdata = {13'h0, phy_link, 2'b00};
      else if (md_req_reg == stat_reg) md_rsp_rdata = phy_stat;
      else md_rsp_rdata = 16'hDEAD;
      busy = 1;
      lat = 2;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_log();
    n_req = 0; n_wr = 0; n_other = 0; last_rd = -1; min_gap = 1000000;
  endtask

  task automatic pulse_clear();
    irq_clear = 1'b1;
    wait_cyc(1);
    irq_clear = 1'b0;
    wait_cyc(1);
  endtask

  task automatic t_reset();
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    chk("R1 link_up", link_up, 0);
    chk("R1 link_irq", link_irq, 0);
    chk("R1 cfg", {speed_10, half_duplex, flow_off}, 0);
    chk("R1 req", n_req, 0);
  endtask

  task automatic t_forced();
    wait_cyc(10);
    chk("R7 link down", link_up, 0);
    chk("R7 no requests", n_req, 0);
    mode = 2'b11;
    force_cfg = 3'b101;
    wait_cyc(5);
    chk("R8 link up", link_up, 1);
    chk("R8 cfg 101", {speed_10, half_duplex, flow_off}, 3'b101);
    force_cfg = 3'b010;
    wait_cyc(5);
    chk("R8 cfg 010", {speed_10, half_duplex, flow_off}, 3'b010);
    chk("R8 no requests", n_req, 0);
  endtask

  task automatic t_hw_neg();
    phy_link = 1'b1;
    phy_stat = 16'h0003;
    clear_log();
    mode = 2'b00;
    wait_cyc(100);
    chk("R2 first is write", lw[0], 1);
    chk("R2 first reg", lr[0], 4);
    chk("R2 first data", ld[0], 16'h01E1);
    chk("R2 second is write", lw[1], 1);
    chk("R2 second reg", lr[1], 0);
    chk("R2 second data", ld[1], 16'h1200);
    chk("R3 status read", {lw[2], lr[2]}, 6'd1);
    chk("R3 resolved read", {lw[3], lr[3]}, 6'd17);
    chk("R3 link_up", link_up, 1);
    chk("R3 cfg from resolved", {speed_10, half_duplex, flow_off}, 3'b001);
    chk("R5 irq on link up", link_irq, 1);
    pulse_clear();
    chk("R6 irq cleared", link_irq, 0);
  endtask

  task automatic t_poll();
    mode = 2'b01;
    wait_cyc(20);
    clear_log();
    wait_cyc(80);
    chk("R4 no writes", n_wr, 0);
    chk("R4 only reg1", n_other, 0);
    chk("R4 link follows", link_up, 1);
    chk("R13 no irq on mode switch", link_irq, 0);
    force_cfg = 3'b111;
    wait_cyc(40);
    chk("R9 force_cfg ignored", {speed_10, half_duplex, flow_off}, 3'b001);
    phy_link = 1'b0;
    wait_cyc(60);
    chk("R4 link down seen", link_up, 0);
    chk("R5 irq on link down", link_irq, 1);
    wait_cyc(60);
    chk("R5 irq sticky", link_irq, 1);
    chk("R11 poll spacing", min_gap >= 20, 1);
    chk("R4 still no writes", n_wr, 0);
    pulse_clear();
    chk("R6 irq cleared again", link_irq, 0);
  endtask

  task automatic t_sw_flow();
    phy_link = 1'b1;
    wait_cyc(60);
    chk("R5 irq on link return", link_irq, 1);
    pulse_clear();
    mode = 2'b11;
    force_cfg = 3'b110;
    wait_cyc(5);
    mode = 2'b01;
    wait_cyc(80);
    chk("R13 no irq after forced", link_irq, 0);
    chk("R13 link up", link_up, 1);
    chk("R9 cfg kept from forced", {speed_10, half_duplex, flow_off}, 3'b110);
  endtask

  task automatic t_restart();
    wait_cyc(7);
    clear_log();
    mode = 2'b00;
    wait_cyc(30);
    chk("R12 restart write", lw[0], 1);
    chk("R12 restart reg", lr[0], 4);
    chk("R10 single outstanding", overlap, 0);
  endtask

  initial begin
    t_reset();
    t_forced();
    t_hw_neg();
    t_poll();
    t_sw_flow();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule